// File: doc/BRIEF.md
# Address-Decoded Design Port Multiplexer

This block is one multiplexer unit on a shared bus that many such units tap. Each unit has a fixed 5-bit unit address, set by a parameter, and serves up to 16 user design slots. A 10-bit select field and an enable run along the bus. When the enable is high and the select field names this unit, the unit passes the bus inputs to one slot. These inputs are the user clock, the active-low user reset, the user inputs and the bidirectional inputs. The unit then drives that slot's outputs, output enables and bidirectional outputs back onto the bus.

All other slots see zeros on every input, including their clock and reset. A unit that is not addressed releases the bus. A real tristate driver is modelled here as a `bus_drive` flag together with output vectors that are forced to zero. The bus can then merge all units with an AND-OR tree. Units with distinct addresses never drive the bus together.

The block has no storage and no flow control. It routes combinationally, so there is no stream handshake and no back-pressure.

Top module: `pmux_unit`

## Requirements
- R1: A slot is selected only when `bus_ena` is 1 and `bus_sel[9:5]` equals the parameter `UNIT_ADDR`.
- R2: The selected slot has index `bus_sel[3:0]`. Its `dsg_ui` slice equals `bus_ui`, where bit 0 is the user clock, bit 1 is the active-low user reset and bits 9:2 are the user inputs. Its `dsg_uio_in` slice equals `bus_uio_in`.
- R3: At most one slot is selected. Every slot that is not selected sees all of its `dsg_ui` and `dsg_uio_in` bits at 0.
- R4: With `bus_ena` at 0, no slot receives input and `bus_drive` is 0, whatever `bus_sel` holds.
- R5: While a slot is selected, `bus_drive` is 1, and `bus_uo`, `bus_uio_out` and `bus_uio_oe` equal that slot's `dsg_uo`, `dsg_uio_out` and `dsg_uio_oe` slices.
- R6: While `bus_drive` is 0, `bus_uo`, `bus_uio_out` and `bus_uio_oe` are all 0, so an AND-OR bus merge ignores the unit.
- R7: With `bus_sel[4]` at 1, no slot is selected and the unit does not drive.
- R8: An index `bus_sel[3:0]` at or above the parameter `N_SLOTS` selects no slot and produces no drive.
- R9: Two units with different `UNIT_ADDR` never both assert `bus_drive`. The OR of their outputs equals the outputs of the one that drives.
- R10: Routing has zero latency. Outputs reflect the current inputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_ena | input | 1 | Bus enable |
| bus_sel | input | 10 | Select field: [9:5] unit address, [4] guard, [3:0] slot index |
| bus_ui | input | UI_W (10) | Bus clock, reset and user inputs |
| bus_uio_in | input | UIO_W (8) | Bus bidirectional inputs |
| dsg_uo | input | N_SLOTS*UO_W | Per-slot user outputs, slot k at [k*UO_W +: UO_W] |
| dsg_uio_out | input | N_SLOTS*UIO_W | Per-slot bidirectional outputs |
| dsg_uio_oe | input | N_SLOTS*UIO_W | Per-slot bidirectional output enables |
| dsg_ui | output | N_SLOTS*UI_W | Per-slot gated clock, reset and inputs |
| dsg_uio_in | output | N_SLOTS*UIO_W | Per-slot gated bidirectional inputs |
| bus_drive | output | 1 | Unit drives the bus (tristate enable model) |
| bus_uo | output | UO_W (8) | Steered user outputs, zero when released |
| bus_uio_out | output | UIO_W (8) | Steered bidirectional outputs, zero when released |
| bus_uio_oe | output | UIO_W (8) | Steered output enables, zero when released |

## Verification
Every result of this block is due in the same cycle as its stimulus. Slot inputs, the drive flag and the bus outputs are all combinational functions of the present bus and slot values. The bench changes inputs on the falling clock edge and samples 2 ns later, well before the next rising edge, so each check sees exactly one input set. The bench sweeps every select value with the enable both low and high. A small unit is used for the sweep (12 slots), so the unpopulated indices are covered. A second unit with another address sits beside the first to check bus sharing.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  localparam int SEL_W     = 10;
  localparam int UNIT_W    = 5;
  localparam int UNIT_LSB  = 5;
  localparam int GUARD_BIT = 4;
  localparam int IDX_W     = 4;
  localparam int MAX_SLOTS = 1 << IDX_W;
endpackage

// File: rtl/pmux_addr_match.sv
module pmux_addr_match
  import pmux_pkg::*;
#(
  parameter logic [UNIT_W-1:0] UNIT_ADDR = '0,
  parameter int                N_SLOTS   = MAX_SLOTS
) (
  input  logic             bus_ena,
  input  logic [SEL_W-1:0] bus_sel,
  output logic [N_SLOTS-1:0] slot_sel
);
  logic             unit_hit;
  logic [IDX_W-1:0] slot_idx;

  assign unit_hit = bus_ena
                 && (bus_sel[UNIT_LSB +: UNIT_W] == UNIT_ADDR)
                 && !bus_sel[GUARD_BIT];
  assign slot_idx = bus_sel[IDX_W-1:0];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_dec
    assign slot_sel[g] = unit_hit && (slot_idx == IDX_W'(g));
  end

  always_comb begin
    if (!$isunknown(slot_sel)) begin
      // R3
      sel_onehot_chk: assert ($onehot0(slot_sel));
    end
    if (!$isunknown({bus_ena, slot_sel}) && !bus_ena) begin
      // R4
      ena_low_idle_chk: assert (slot_sel == '0);
    end
  end
endmodule

// File: rtl/pmux_in_gate.sv
module pmux_in_gate #(
  parameter int N_SLOTS = 16,
  parameter int W       = 10
) (
  input  logic [W-1:0]         bus_val,
  input  logic [N_SLOTS-1:0]   slot_sel,
  output logic [N_SLOTS*W-1:0] slot_val
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_gate
    assign slot_val[g*W +: W] = bus_val & {W{slot_sel[g]}};
  end
endmodule

// File: rtl/pmux_out_steer.sv
module pmux_out_steer #(
  parameter int N_SLOTS = 16,
  parameter int W       = 8
) (
  input  logic [N_SLOTS*W-1:0] slot_val,
  input  logic [N_SLOTS-1:0]   slot_sel,
  output logic [W-1:0]         bus_val
);
  always_comb begin
    bus_val = '0;
    for (int g = 0; g < N_SLOTS; g++) begin
      bus_val = bus_val | (slot_val[g*W +: W] & {W{slot_sel[g]}});
    end
  end
endmodule

// File: rtl/pmux_unit.sv
module pmux_unit
  import pmux_pkg::*;
#(
  parameter logic [UNIT_W-1:0] UNIT_ADDR = '0,
  parameter int                N_SLOTS   = MAX_SLOTS,
  parameter int                UI_W      = 10,
  parameter int                UIO_W     = 8,
  parameter int                UO_W      = 8
) (
  input  logic                     bus_ena,
  input  logic [SEL_W-1:0]         bus_sel,
  input  logic [UI_W-1:0]          bus_ui,
  input  logic [UIO_W-1:0]         bus_uio_in,
  input  logic [N_SLOTS*UO_W-1:0]  dsg_uo,
  input  logic [N_SLOTS*UIO_W-1:0] dsg_uio_out,
  input  logic [N_SLOTS*UIO_W-1:0] dsg_uio_oe,
  output logic [N_SLOTS*UI_W-1:0]  dsg_ui,
  output logic [N_SLOTS*UIO_W-1:0] dsg_uio_in,
  output logic                     bus_drive,
  output logic [UO_W-1:0]          bus_uo,
  output logic [UIO_W-1:0]         bus_uio_out,
  output logic [UIO_W-1:0]         bus_uio_oe
);
  logic [N_SLOTS-1:0] slot_sel;

  pmux_addr_match #(.UNIT_ADDR(UNIT_ADDR), .N_SLOTS(N_SLOTS)) u_match (
    .bus_ena (bus_ena),
    .bus_sel (bus_sel),
    .slot_sel(slot_sel)
  );

  pmux_in_gate #(.N_SLOTS(N_SLOTS), .W(UI_W)) u_gate_ui (
    .bus_val(bus_ui), .slot_sel(slot_sel), .slot_val(dsg_ui)
  );
  pmux_in_gate #(.N_SLOTS(N_SLOTS), .W(UIO_W)) u_gate_uio (
    .bus_val(bus_uio_in), .slot_sel(slot_sel), .slot_val(dsg_uio_in)
  );

  pmux_out_steer #(.N_SLOTS(N_SLOTS), .W(UO_W)) u_steer_uo (
    .slot_val(dsg_uo), .slot_sel(slot_sel), .bus_val(bus_uo)
  );
  pmux_out_steer #(.N_SLOTS(N_SLOTS), .W(UIO_W)) u_steer_out (
    .slot_val(dsg_uio_out), .slot_sel(slot_sel), .bus_val(bus_uio_out)
  );
  pmux_out_steer #(.N_SLOTS(N_SLOTS), .W(UIO_W)) u_steer_oe (
    .slot_val(dsg_uio_oe), .slot_sel(slot_sel), .bus_val(bus_uio_oe)
  );

  assign bus_drive = |slot_sel;

  always_comb begin
    if (!$isunknown({bus_drive, bus_uo, bus_uio_out, bus_uio_oe}) && !bus_drive) begin
      // R6
      released_zero_chk: assert ((bus_uo == '0) && (bus_uio_out == '0) && (bus_uio_oe == '0));
    end
    if (!$isunknown({bus_drive, bus_sel}) && bus_drive) begin
      // R8
      slot_range_chk: assert (32'(bus_sel[IDX_W-1:0]) < N_SLOTS);
      // R7
      guard_clear_chk: assert (!bus_sel[GUARD_BIT]);
      // R1
      addr_match_chk: assert (bus_ena && (bus_sel[UNIT_LSB +: UNIT_W] == UNIT_ADDR));
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_quiet
    always_comb begin
      if (!$isunknown({dsg_ui[g*UI_W +: UI_W], dsg_uio_in[g*UIO_W +: UIO_W], bus_drive, bus_sel})
          && ((|dsg_ui[g*UI_W +: UI_W]) || (|dsg_uio_in[g*UIO_W +: UIO_W]))) begin
        // R3
        quiet_slot_chk: assert (bus_drive && (bus_sel[IDX_W-1:0] == IDX_W'(g)));
      end
    end
  end
endmodule

// File: tb/test_pmux_unit.sv
module test_pmux_unit;
  localparam int NS = 12;
  localparam logic [4:0] ADDR_A = 5'd19;
  localparam logic [4:0] ADDR_B = 5'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          bus_ena;
  logic [9:0]    bus_sel;
  logic [9:0]    bus_ui;
  logic [7:0]    bus_uio_in;
  logic [NS*8-1:0]  dsg_uo, dsg_uio_out, dsg_uio_oe;
  logic [NS*10-1:0] a_ui, b_ui;
  logic [NS*8-1:0]  a_uio, b_uio;
  logic          a_drv, b_drv;
  logic [7:0]    a_uo, a_out, a_oe, b_uo, b_out, b_oe;

  pmux_unit #(.UNIT_ADDR(ADDR_A), .N_SLOTS(NS)) i_pmux_unit (
    .bus_ena(bus_ena), .bus_sel(bus_sel), .bus_ui(bus_ui), .bus_uio_in(bus_uio_in),
    .dsg_uo(dsg_uo), .dsg_uio_out(dsg_uio_out), .dsg_uio_oe(dsg_uio_oe),
    .dsg_ui(a_ui), .dsg_uio_in(a_uio), .bus_drive(a_drv),
    .bus_uo(a_uo), .bus_uio_out(a_out), .bus_uio_oe(a_oe)
  );
  pmux_unit #(.UNIT_ADDR(ADDR_B), .N_SLOTS(NS)) i_peer (
    .bus_ena(bus_ena), .bus_sel(bus_sel), .bus_ui(bus_ui), .bus_uio_in(bus_uio_in),
    .dsg_uo(dsg_uo), .dsg_uio_out(dsg_uio_out), .dsg_uio_oe(dsg_uio_oe),
    .dsg_ui(b_ui), .dsg_uio_in(b_uio), .bus_drive(b_drv),
    .bus_uo(b_uo), .bus_uio_out(b_out), .bus_uio_oe(b_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_uo(int k);  return 8'(k * 37 + 5); endfunction
  function automatic logic [7:0] pat_out(int k); return 8'((k * 11) ^ 8'hA5); endfunction
  function automatic logic [7:0] pat_oe(int k);  return 8'(~(k * 3)); endfunction

  initial begin
    for (int k = 0; k < NS; k++) begin
      dsg_uo[k*8 +: 8]      = pat_uo(k);
      dsg_uio_out[k*8 +: 8] = pat_out(k);
      dsg_uio_oe[k*8 +: 8]  = pat_oe(k);
    end
    bus_ena = 1'b0; bus_sel = 10'h3FF; bus_ui = 10'h3FF; bus_uio_in = 8'hFF;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R4: idle state after reset, enable low
    chk("R4 idle drive", 32'(a_drv), 32'd0);
    chk("R4 idle slot inputs", 32'(|a_ui | |a_uio), 32'd0);
    chk("R6 idle bus outputs", 32'({a_uo, a_out, a_oe}), 32'd0);

    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 1024; s++) begin
        logic [9:0] sv;
        logic hit_a, hit_b;
        int idx;
        string why;
        @(negedge clk);
        sv = 10'(s);
        bus_ena = e[0]; bus_sel = sv;
        bus_ui = 10'(s * 7 + 3); bus_uio_in = 8'(s ^ 8'h5A);
        #2; // R10: same-cycle sample
        idx = s % 16;
        hit_a = e[0] && (sv[9:5] == ADDR_A) && !sv[4] && (idx < NS);
        hit_b = e[0] && (sv[9:5] == ADDR_B) && !sv[4] && (idx < NS);
        if (!e[0]) why = "R4";
        else if (sv[9:5] != ADDR_A) why = "R1";
        else if (sv[4]) why = "R7";
        else if (idx >= NS) why = "R8";
        else why = "R3";
        for (int k = 0; k < NS; k++) begin
          logic sel_k;
          sel_k = hit_a && (k == idx);
          chk(sel_k ? "R2 R10 slot ui" : {why, " slot ui"},
              32'(a_ui[k*10 +: 10]), sel_k ? 32'(bus_ui) : 32'd0);
          chk(sel_k ? "R2 slot uio_in" : {why, " slot uio_in"},
              32'(a_uio[k*8 +: 8]), sel_k ? 32'(bus_uio_in) : 32'd0);
        end
        chk(hit_a ? "R5 R10 drive" : {why, " drive"}, 32'(a_drv), 32'(hit_a));
        chk(hit_a ? "R5 outputs" : "R6 released outputs", 32'({a_uo, a_out, a_oe}),
            hit_a ? 32'({pat_uo(idx), pat_out(idx), pat_oe(idx)}) : 32'd0);
        chk("R9 peer drive", 32'(b_drv), 32'(hit_b));
        chk("R9 single driver", 32'(a_drv & b_drv), 32'd0);
        chk("R9 merged bus", 32'({a_uo | b_uo, a_out | b_out, a_oe | b_oe}),
            (hit_a || hit_b) ? 32'({pat_uo(idx), pat_out(idx), pat_oe(idx)}) : 32'd0);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule